// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Serial Converter Register Core

This block is the digital register side of a four-channel, 12-bit serial-input converter. A fast system clock samples seven slow external pins through two-flop synchronisers: serial data, serial clock, chip select, an active-low load-register strobe, an active-low load-all strobe, an active-low clear and a clear-code select. Serial clock and chip select are combined with a logical OR. Each rising edge of that combined clock, detected in the system clock domain, shifts one data bit into a 16-bit frame register.

A frame holds a 2-bit channel address in its two oldest bits, then two bits that are ignored, then a 12-bit code sent most significant bit first. Two banks of four 12-bit registers follow the frame register. The input bank is written by the load-register strobe at the addressed channel. The output bank copies all four input registers under the load-all strobe. Both strobes behave as level-transparent latches, modelled in the clock domain. The clear pin forces both banks to zero-scale or to mid-scale and leaves the frame register as it is. The four output codes drive the converters.

Top module: `quad_dac_regcore`

## Requirements
- R1: After system reset every output code is 000h.
- R2: The frame register shifts one bit, taking the serial data value, on each rising edge of (chip select OR serial clock), and does not shift at any other time. The newest bit enters at bit 0. After 16 shifts, bits [15:14] hold the address and bits [11:0] hold the code. Bits [13:12] are ignored.
- R3: Address 00 selects channel 0 (A), 01 channel 1 (B), 10 channel 2 (C) and 11 channel 3 (D). Channel k appears on `dac_codes[12k+11:12k]`.
- R4: While the load-register strobe is low, the addressed input register follows the frame register's code field. While it is high, all input registers hold, so shifting a frame has no effect on them.
- R5: While the load-all strobe is low, all four output registers follow their input registers. While it is high, the outputs hold.
- R6: Bits shifted while the load-register strobe is low overwrite each channel whose address passes through bits [15:14], each with the code field present at that moment.
- R7: While the clear pin is low, every input and output register is forced to 800h if clear-select is high and to 000h if it is low. The frame register keeps its contents.
- R8: When the clear pin is released, registers whose strobe is high keep the clear value.
- R9: If chip select rises while the serial clock is low, that edge shifts one extra bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial pins |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sdi_pin | input | 1 | Serial data |
| sck_pin | input | 1 | Serial clock |
| csel_pin | input | 1 | Chip select, ORed with the serial clock |
| ldreg_n_pin | input | 1 | Active-low load strobe for the addressed input register |
| ldall_n_pin | input | 1 | Active-low load strobe for all output registers |
| clr_n_pin | input | 1 | Active-low clear of both register banks |
| clrsel_pin | input | 1 | Clear code select: 0 gives 000h, 1 gives 800h |
| dac_codes | output | 48 | Four output codes, channel k at bits [12k+11:12k] |

## Verification
The main frame path is tested with directed frames to each of the four addresses, with the ignored bits set to ones. This shows whether address decoding selects the right channel and whether the pad bits leak into the code. Three strobe patterns follow: a load-register pulse and then a load-all pulse, a load-all strobe held low, and a load-register strobe held low during shifting. These show hold against transparency in each bank, and the overwrite of every channel an address passes through. Clear pulses with both select values, followed by a load-register pulse with no new frame, show that the clear code is right and that the frame register survives a clear. A frame ending with chip select rising while the serial clock is low shows the extra shift. Randomised frames then mix all of these patterns.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned NUM_PINS = 7;
  localparam int unsigned P_SDI    = 0;
  localparam int unsigned P_SCK    = 1;
  localparam int unsigned P_CSEL   = 2;
  localparam int unsigned P_LDREG  = 3;
  localparam int unsigned P_LDALL  = 4;
  localparam int unsigned P_CLR    = 5;
  localparam int unsigned P_CLRSEL = 6;
  // idle levels: clocks and active-low strobes high, data and select low
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 7'b0111110;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned PAD_W  = 2,
  parameter int unsigned CODE_W = 12,
  localparam int unsigned FRAME_W = ADDR_W + PAD_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              sdi,
  input  logic              sck,
  input  logic              csel,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [CODE_W-1:0] frame_code
);
  logic               shclk;
  logic               shclk_q;
  logic               rise;
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_d;

  assign shclk = sck | csel;
  assign rise  = shclk & ~shclk_q;

  always_comb begin
    sr_d = {sr_q[FRAME_W-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) shclk_q <= 1'b1;
    else         shclk_q <= shclk;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)   sr_q <= '0;
    else if (rise) sr_q <= sr_d;
  end

  assign frame_addr = sr_q[FRAME_W-1 -: ADDR_W];
  assign frame_code = sr_q[CODE_W-1:0];

  // R2
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !(sck | csel) || $past(sck | csel) |=> $stable(sr_q))
    else $error("frame register moved without a shift edge");

  // R2
  sr_take_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ((sck | csel) && !shclk_q) |=> (sr_q[0] == $past(sdi)) &&
      (sr_q[FRAME_W-1:1] == $past(sr_q[FRAME_W-2:0])))
    else $error("frame register did not shift correctly");
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CODE_W = 12,
  localparam int unsigned ADDR_W = $clog2(NCH)
) (
  input  logic                       clk,
  input  logic                       rst_ns,
  input  logic [ADDR_W-1:0]          frame_addr,
  input  logic [CODE_W-1:0]          frame_code,
  input  logic                       ldreg_n,
  input  logic                       ldall_n,
  input  logic                       clr_n,
  input  logic                       clrsel,
  output logic [NCH-1:0][CODE_W-1:0] out_q
);
  logic [CODE_W-1:0]          clr_code;
  logic [NCH-1:0][CODE_W-1:0] in_q;
  logic [NCH-1:0][CODE_W-1:0] in_d;
  logic [NCH-1:0][CODE_W-1:0] out_d;
  logic [NCH-1:0]             wr;
  logic [NCH-1:0]             in_en;
  logic                       out_en;

  assign clr_code = {clrsel, {(CODE_W-1){1'b0}}};
  assign out_en   = ~clr_n | ~ldall_n;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign wr[k]    = ~ldreg_n & (frame_addr == ADDR_W'(k));
    assign in_en[k] = ~clr_n | wr[k];

    always_comb begin
      if (!clr_n)     in_d[k] = clr_code;
      else if (wr[k]) in_d[k] = frame_code;
      else            in_d[k] = in_q[k];
      if (!clr_n)     out_d[k] = clr_code;
      else            out_d[k] = in_d[k];
    end

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns)       in_q[k] <= '0;
      else if (in_en[k]) in_q[k] <= in_d[k];
    end

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns)     out_q[k] <= '0;
      else if (out_en) out_q[k] <= out_d[k];
    end

    // R7
    clr_force_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      !clr_n |=> (out_q[k] == {$past(clrsel), {(CODE_W-1){1'b0}}}) &&
                 (in_q[k] == out_q[k]))
      else $error("clear did not force channel %0d", k);
  end

  // R4
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (ldreg_n && clr_n) |=> $stable(in_q))
    else $error("input bank changed while its strobe was high");

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (ldall_n && clr_n) |=> $stable(out_q))
    else $error("output bank changed while its strobe was high");

  // R5
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!ldall_n && clr_n && ldreg_n) |=> (out_q == in_q))
    else $error("output bank not transparent");
endmodule

// File: rtl/quad_dac_regcore.sv
module quad_dac_regcore
  import qdac_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned PAD_W  = 2,
  localparam int unsigned ADDR_W = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sdi_pin,
  input  logic                  sck_pin,
  input  logic                  csel_pin,
  input  logic                  ldreg_n_pin,
  input  logic                  ldall_n_pin,
  input  logic                  clr_n_pin,
  input  logic                  clrsel_pin,
  output logic [NCH*CODE_W-1:0] dac_codes
);
  logic [1:0]          rst_pipe;
  logic                rst_ns;
  logic [NUM_PINS-1:0] pins_raw;
  logic [NUM_PINS-1:0] pins_s;
  logic [ADDR_W-1:0]   frame_addr;
  logic [CODE_W-1:0]   frame_code;
  logic [NCH-1:0][CODE_W-1:0] codes;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  always_comb begin
    pins_raw           = '0;
    pins_raw[P_SDI]    = sdi_pin;
    pins_raw[P_SCK]    = sck_pin;
    pins_raw[P_CSEL]   = csel_pin;
    pins_raw[P_LDREG]  = ldreg_n_pin;
    pins_raw[P_LDALL]  = ldall_n_pin;
    pins_raw[P_CLR]    = clr_n_pin;
    pins_raw[P_CLRSEL] = clrsel_pin;
  end

  qdac_sync #(.W(NUM_PINS), .RST_VAL(PIN_IDLE)) u_sync (
    .clk    (clk),
    .rst_ns (rst_ns),
    .din    (pins_raw),
    .dout   (pins_s)
  );

  qdac_shifter #(.ADDR_W(ADDR_W), .PAD_W(PAD_W), .CODE_W(CODE_W)) u_shift (
    .clk        (clk),
    .rst_ns     (rst_ns),
    .sdi        (pins_s[P_SDI]),
    .sck        (pins_s[P_SCK]),
    .csel       (pins_s[P_CSEL]),
    .frame_addr (frame_addr),
    .frame_code (frame_code)
  );

  qdac_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_bank (
    .clk        (clk),
    .rst_ns     (rst_ns),
    .frame_addr (frame_addr),
    .frame_code (frame_code),
    .ldreg_n    (pins_s[P_LDREG]),
    .ldall_n    (pins_s[P_LDALL]),
    .clr_n      (pins_s[P_CLR]),
    .clrsel     (pins_s[P_CLRSEL]),
    .out_q      (codes)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_out
    assign dac_codes[k*CODE_W +: CODE_W] = codes[k];
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    $rose(rst_ns) |-> (dac_codes == '0))
    else $error("outputs not zero after reset");
endmodule

// File: tb/tb_quad_dac_regcore.sv
module tb_quad_dac_regcore;
  localparam int SDI = 0, SCK = 1, CS = 2, LDREG = 3, LDALL = 4, CLR = 5, CLRSEL = 6;

  logic        clk;
  logic        rst_n;
  bit   [6:0]  pv;
  logic [47:0] dac_codes;

  bit   [15:0] m_sr;
  bit   [11:0] m_in  [4];
  bit   [11:0] m_out [4];
  int          vectors;
  int          miscompares;
  bit          done;

  quad_dac_regcore dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sdi_pin     (pv[SDI]),
    .sck_pin     (pv[SCK]),
    .csel_pin    (pv[CS]),
    .ldreg_n_pin (pv[LDREG]),
    .ldall_n_pin (pv[LDALL]),
    .clr_n_pin   (pv[CLR]),
    .clrsel_pin  (pv[CLRSEL]),
    .dac_codes   (dac_codes)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit [11:0] clear_code(bit sel);
    return sel ? 12'h800 : 12'h000;
  endfunction

  function automatic bit [15:0] make_frame(bit [1:0] addr, bit [11:0] code);
    return {addr, 2'b11, code};
  endfunction

  // level behaviour of both banks, per the requirements
  function automatic void model_levels();
    if (!pv[CLR]) begin
      for (int k = 0; k < 4; k++) begin
        m_in[k]  = clear_code(pv[CLRSEL]);
        m_out[k] = clear_code(pv[CLRSEL]);
      end
    end else begin
      if (!pv[LDREG]) m_in[m_sr[15:14]] = m_sr[11:0];
      if (!pv[LDALL]) for (int k = 0; k < 4; k++) m_out[k] = m_in[k];
    end
  endfunction

  task automatic drive(int idx, bit v);
    bit was;
    was = pv[SCK] | pv[CS];
    pv[idx] = v;
    if (!was && (pv[SCK] | pv[CS])) m_sr = {m_sr[14:0], pv[SDI]};
    model_levels();
    repeat (6) @(posedge clk);
  endtask

  task automatic send_frame(bit [15:0] w, bit extra, bit xbit);
    drive(CS, 1'b0);
    for (int i = 15; i >= 0; i--) begin
      drive(SCK, 1'b0);
      drive(SDI, w[i]);
      drive(SCK, 1'b1);
    end
    if (extra) begin
      drive(SCK, 1'b0);
      drive(SDI, xbit);
      drive(CS, 1'b1);
      drive(SCK, 1'b1);
    end else begin
      drive(CS, 1'b1);
    end
  endtask

  task automatic pulse(int idx);
    drive(idx, 1'b0);
    drive(idx, 1'b1);
  endtask

  task automatic check_outs(string tag);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      vectors++;
      if (dac_codes[k*12 +: 12] !== m_out[k]) begin
        miscompares++;
        $display("FAIL %s ch%0d actual %03h expected %03h", tag, k,
                 dac_codes[k*12 +: 12], m_out[k]);
      end
    end
  endtask

  task automatic check_one(string tag, int k, bit [11:0] exp);
    @(negedge clk);
    vectors++;
    if (dac_codes[k*12 +: 12] !== exp) begin
      miscompares++;
      $display("FAIL %s ch%0d actual %03h expected %03h", tag, k,
               dac_codes[k*12 +: 12], exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    bit [15:0] w;
    void'($urandom(32'h5eed1234));
    vectors = 0;
    miscompares = 0;
    done = 1'b0;
    pv = 7'b0111110;
    m_sr = '0;
    for (int k = 0; k < 4; k++) begin m_in[k] = '0; m_out[k] = '0; end
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    check_outs("R1 reset state");

    // frame, load-register pulse, then load-all pulse
    for (int k = 0; k < 4; k++) begin
      send_frame(make_frame(2'(k), 12'h100 * 12'(k + 1) + 12'h05a), 1'b0, 1'b0);
      pulse(LDREG);
    end
    check_outs("R5 outputs hold before load-all");
    check_one("R5 hold ch0", 0, 12'h000);
    pulse(LDALL);
    check_outs("R2 R3 frame decode");
    check_one("R3 channel C gets address 10", 2, 12'h35a);
    check_one("R2 pad bits ignored ch3", 3, 12'h45a);

    // load-all held low: outputs update as soon as load-register drops
    drive(LDALL, 1'b0);
    send_frame(make_frame(2'b01, 12'habc), 1'b0, 1'b0);
    check_one("R4 no load while strobe high", 1, 12'h25a);
    pulse(LDREG);
    check_one("R5 transparent output", 1, 12'habc);
    check_outs("R4 R5 immediate update");

    // shifting with load-register low overwrites passing channels
    drive(LDREG, 1'b0);
    send_frame(make_frame(2'b10, 12'h5a5), 1'b0, 1'b0);
    drive(LDREG, 1'b1);
    check_outs("R6 shift while load-register low");
    check_one("R6 final channel", 2, 12'h5a5);

    // clear to mid-scale, frame register retained
    drive(LDALL, 1'b1);
    drive(CLRSEL, 1'b1);
    pulse(CLR);
    for (int k = 0; k < 4; k++) check_one("R7 clear mid-scale", k, 12'h800);
    check_outs("R8 clear value kept after release");
    drive(LDALL, 1'b0);
    check_outs("R8 outputs follow cleared inputs");
    pulse(LDREG);
    check_one("R7 frame register survives clear", 2, 12'h5a5);
    drive(CLRSEL, 1'b0);
    pulse(CLR);
    for (int k = 0; k < 4; k++) check_one("R7 clear zero-scale", k, 12'h000);

    // extra shift when chip select rises with serial clock low
    w = make_frame(2'b00, 12'h3c3);
    send_frame(w, 1'b1, 1'b1);
    pulse(LDREG);
    check_outs("R9 extra bit");
    check_one("R9 shifted frame lands on channel B", 1, 12'h787);

    // randomised mix
    for (int n = 0; n < 110; n++) begin
      bit [31:0] r;
      r = $urandom;
      drive(LDALL, r[0] & r[1]);
      send_frame(16'($urandom), (r[4:2] == 3'd0), r[5]);
      if (r[6]) pulse(LDREG);
      if (r[7]) pulse(LDALL);
      if (r[12:8] == 5'd0) begin
        drive(CLRSEL, r[13]);
        pulse(CLR);
      end
      check_outs("R2 R4 R5 random");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule